// File: doc/BRIEF.md
# Bitmap-Intersection Multi-Field Classifier

This block finds the best matching rule for a packet described by several header fields. Each field axis is divided into elementary intervals, and each interval carries a rule bitmap computed ahead of time. Bit `RULES-1-k` of that bitmap is set when rule k covers the interval. A query locates the interval that holds each field value, with all fields searched at the same time. It then ANDs the selected bitmaps into one intersection and reports the highest-priority rule present in it.

Tables are written through a single load port that has a field select. A table is always rebuilt as a whole, because editing one rule in place is not supported. Each field's lookup engine scans its sorted boundary list, one entry per cycle. The query port and the result port each use a valid/ready handshake, and only one query is in flight at a time.

Top module: `bmi_classifier`

## Requirements
- R1: A load cycle with `ld_en` high while `q_ready` is high writes boundary `ld_bound` and bitmap `ld_map` into entry `ld_idx` of the table chosen by `ld_dim`. When `ld_last` is set, that table's active entry count becomes `ld_idx+1`.
- R2: For each field, the selected bitmap comes from the highest-indexed active entry whose boundary is less than or equal to the field value. The boundaries are loaded in strictly ascending order. If the value lies below the first boundary, or the table has no active entries, the selected bitmap is all zeros.
- R3: `res_map` equals the bitwise AND of the bitmaps selected for all fields.
- R4: Rule k (k = 0 is the top rule) occupies bitmap bit `RULES-1-k`, so the most significant bit has the highest priority. `res_idx` is the smallest k whose bit is set in `res_map`.
- R5: `res_hit` is 1 exactly when `res_map` is nonzero. When `res_map` is zero, `res_idx` is 0.
- R6: `q_ready` is high only while no query is being searched or waiting in the result register. A query is taken in a cycle where `q_valid` and `q_ready` are both high. The field for field select d occupies bits `[d*FIELD_W +: FIELD_W]` of `q_key`.
- R7: Once `res_valid` rises, it stays high and `res_hit`, `res_idx` and `res_map` stay unchanged until a cycle in which `res_ready` is high.
- R8: A load cycle while `q_ready` is low has no effect on any table.
- R9: With six rules, a first-field bitmap of 010011 and a second-field bitmap of 000111 intersect to 000011, and the result is rule index 4 with a hit.
- R10: After a reload that sets a smaller active count, entries beyond the new count are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Table write strobe |
| ld_dim | input | DIM_W | Field table select |
| ld_idx | input | IDX_W | Entry index within the table |
| ld_bound | input | FIELD_W | Interval lower boundary |
| ld_map | input | RULES | Rule bitmap for the interval |
| ld_last | input | 1 | Marks the final entry, which sets the active count |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Query port can accept |
| q_key | input | FIELDS*FIELD_W | Packed field values |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_hit | output | 1 | Some rule matches |
| res_idx | output | RES_W | Index of the best rule |
| res_map | output | RULES | Intersection bitmap |

## Verification
Fixed tables reproduce the six-rule worked example. They also probe a key that lies exactly on a boundary, a key below the first boundary and a pair of bitmaps whose intersection is empty. Together these separate an off-by-one lookup, a wrong comparison sense and a missing hit gate. Random sorted tables with random counts, queried with random keys, exercise priority encoding across many intersection patterns. A stalled result with a load attempted during the stall separates register holding from table write gating. A shrinking reload shows whether stale entries are still scanned.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RESULT = 2'd2
  } bmi_state_e;
endpackage

// File: rtl/bmi_range_lookup.sv
module bmi_range_lookup #(
  parameter int FIELD_W = 8,
  parameter int RULES   = 6,
  parameter int ENTRIES = 13,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FIELD_W-1:0] wr_bound,
  input  logic [RULES-1:0]   wr_map,
  input  logic               wr_last,
  input  logic               start,
  input  logic [FIELD_W-1:0] key,
  output logic               busy,
  output logic [RULES-1:0]   map_out
);
  logic [FIELD_W-1:0] bound_q [ENTRIES];
  logic [RULES-1:0]   map_q   [ENTRIES];
  logic [IDX_W:0]     cnt_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [FIELD_W-1:0] key_q;
  logic [RULES-1:0]   acc_q;
  logic               busy_q;

  // named events for the checks
  logic ptr_active;
  logic step_hit;
  logic scan_end;

  assign ptr_active = ({1'b0, ptr_q} < cnt_q);
  assign step_hit   = busy_q && ptr_active && (bound_q[ptr_q] <= key_q);
  assign scan_end   = ({1'b0, ptr_q} + 1'b1) >= cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_idx) < ENTRIES)) begin
      bound_q[wr_idx] <= wr_bound;
      map_q[wr_idx]   <= wr_map;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_en && wr_last && (32'(wr_idx) < ENTRIES)) begin
      cnt_q <= {1'b0, wr_idx} + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      key_q  <= '0;
      acc_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      key_q  <= key;
      acc_q  <= '0;
    end else if (busy_q) begin
      if (step_hit) acc_q <= map_q[ptr_q];
      if (scan_end) busy_q <= 1'b0;
      else          ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign map_out = acc_q;

  // R2: the scan pointer never leaves the table
  p_ptr_in_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (32'(ptr_q) < ENTRIES));

  // R2: the scan is never longer than the active count
  p_scan_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && scan_end) |=> !busy_q);

  // R8: the count is unchanged while a search runs
  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cnt_q));
endmodule

// File: rtl/bmi_first_rule.sv
module bmi_first_rule #(
  parameter int RULES = 6,
  parameter int RES_W = 3
) (
  input  logic [RULES-1:0] map,
  output logic             found,
  output logic [RES_W-1:0] idx
);
  function automatic logic [RES_W-1:0] top_rule(input logic [RULES-1:0] m);
    logic [RES_W-1:0] r;
    r = '0;
    for (int k = RULES - 1; k >= 0; k--) begin
      if (m[RULES-1-k]) r = RES_W'(k);
    end
    return r;
  endfunction

  assign found = |map;
  assign idx   = top_rule(map);
endmodule

// File: rtl/bmi_classifier.sv
module bmi_classifier #(
  parameter int FIELDS  = 2,
  parameter int FIELD_W = 8,
  parameter int RULES   = 6,
  localparam int ENTRIES = 2 * RULES + 1,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int DIM_W   = (FIELDS > 1) ? $clog2(FIELDS) : 1,
  localparam int RES_W   = (RULES > 1) ? $clog2(RULES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [DIM_W-1:0]          ld_dim,
  input  logic [IDX_W-1:0]          ld_idx,
  input  logic [FIELD_W-1:0]        ld_bound,
  input  logic [RULES-1:0]          ld_map,
  input  logic                      ld_last,
  input  logic                      q_valid,
  output logic                      q_ready,
  input  logic [FIELDS*FIELD_W-1:0] q_key,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic                      res_hit,
  output logic [RES_W-1:0]          res_idx,
  output logic [RULES-1:0]          res_map
);
  import bmi_pkg::*;

  bmi_state_e state_q;
  logic [FIELDS-1:0] dim_busy;
  logic [RULES-1:0]  dim_map [FIELDS];
  logic [RULES-1:0]  inter_map;
  logic              inter_found;
  logic [RES_W-1:0]  inter_idx;

  // named events
  logic q_accept;
  logic search_done;
  logic res_take;
  logic load_ok;

  assign q_ready     = (state_q == ST_IDLE);
  assign q_accept    = q_valid && q_ready;
  assign search_done = (state_q == ST_SEARCH) && (dim_busy == '0);
  assign res_take    = (state_q == ST_RESULT) && res_ready;
  assign load_ok     = ld_en && (state_q == ST_IDLE);

  for (genvar d = 0; d < FIELDS; d++) begin : g_dim
    bmi_range_lookup #(
      .FIELD_W(FIELD_W), .RULES(RULES), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) i_lookup (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (load_ok && (ld_dim == DIM_W'(d))),
      .wr_idx  (ld_idx),
      .wr_bound(ld_bound),
      .wr_map  (ld_map),
      .wr_last (ld_last),
      .start   (q_accept),
      .key     (q_key[d*FIELD_W +: FIELD_W]),
      .busy    (dim_busy[d]),
      .map_out (dim_map[d])
    );
  end

  always_comb begin
    inter_map = '1;
    for (int d = 0; d < FIELDS; d++) inter_map = inter_map & dim_map[d];
  end

  bmi_first_rule #(.RULES(RULES), .RES_W(RES_W)) i_first (
    .map  (inter_map),
    .found(inter_found),
    .idx  (inter_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_hit <= 1'b0;
      res_idx <= '0;
      res_map <= '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (q_accept) state_q <= ST_SEARCH;
        ST_SEARCH: if (search_done) begin
          state_q <= ST_RESULT;
          res_hit <= inter_found;
          res_idx <= inter_idx;
          res_map <= inter_map;
        end
        ST_RESULT: if (res_take) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = (state_q == ST_RESULT);

  // R7: the result holds while stalled
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_map) && $stable(res_idx) && $stable(res_hit)));

  // R5: hit agrees with the intersection
  p_hit_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_map != '0)));

  // R4: the reported rule is present and nothing above it is
  p_idx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_map[RULES-1-32'(res_idx)] &&
      ((res_map >> (RULES - 32'(res_idx))) == '0)));

  // R6: no query is taken while a result is held
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !q_ready);

  // R6: each accepted query starts every field search
  p_search_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_accept |=> (dim_busy == '1));
endmodule

// File: tb/test_bmi_classifier.sv
module test_bmi_classifier;
  localparam int FIELDS = 2;
  localparam int FW     = 8;
  localparam int N      = 6;
  localparam int ENT    = 2 * N + 1;
  localparam int IW     = $clog2(ENT);
  localparam int RW     = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [0:0] ld_dim = '0;
  logic [IW-1:0] ld_idx = '0;
  logic [FW-1:0] ld_bound = '0;
  logic [N-1:0] ld_map = '0;
  logic ld_last = 1'b0;
  logic q_valid = 1'b0;
  logic q_ready;
  logic [FIELDS*FW-1:0] q_key = '0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic res_hit;
  logic [RW-1:0] res_idx;
  logic [N-1:0] res_map;

  int checks = 0;
  int errors = 0;

  logic [FW-1:0] m_bnd [FIELDS][ENT];
  logic [N-1:0]  m_map [FIELDS][ENT];
  int            m_cnt [FIELDS];

  always #2.5 clk = ~clk;

  bmi_classifier #(.FIELDS(FIELDS), .FIELD_W(FW), .RULES(N)) i_bmi_classifier (
    .clk, .rst_n, .ld_en, .ld_dim, .ld_idx, .ld_bound, .ld_map, .ld_last,
    .q_valid, .q_ready, .q_key, .res_valid, .res_ready, .res_hit, .res_idx, .res_map
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // search from the top of the active list downwards
  function automatic logic [N-1:0] exp_dim(input int d, input logic [FW-1:0] k);
    for (int i = m_cnt[d] - 1; i >= 0; i--)
      if (m_bnd[d][i] <= k) return m_map[d][i];
    return '0;
  endfunction

  // walk bits upward, the last set bit seen is the top rule
  function automatic int exp_rule(input logic [N-1:0] m);
    int r = 0;
    for (int b = 0; b < N; b++) if (m[b]) r = N - 1 - b;
    return r;
  endfunction

  task automatic load(input int d, input int i, input logic [FW-1:0] b,
                      input logic [N-1:0] m, input logic last, input logic model);
    @(negedge clk);
    ld_en = 1'b1; ld_dim = 1'(d); ld_idx = IW'(i); ld_bound = b; ld_map = m; ld_last = last;
    if (model) begin
      m_bnd[d][i] = b; m_map[d][i] = m;
      if (last) m_cnt[d] = i + 1;
    end
    @(negedge clk);
    ld_en = 1'b0; ld_last = 1'b0;
  endtask

  task automatic query(input logic [FW-1:0] k0, input logic [FW-1:0] k1,
                       input string req, input bit stall);
    logic [N-1:0] em;
    logic [N-1:0] hm;
    logic [RW-1:0] hi;
    logic hh;
    em = exp_dim(0, k0) & exp_dim(1, k1);
    @(negedge clk);
    q_valid = 1'b1; q_key = {k1, k0};
    while (!q_ready) @(negedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check({req, " map"}, 32'(res_map), 32'(em));
    check({req, " hit"}, 32'(res_hit), 32'(em != '0));
    check({req, " idx"}, 32'(res_idx), (em != '0) ? 32'(exp_rule(em)) : 0);
    if (stall) begin
      hm = res_map; hi = res_idx; hh = res_hit;
      // R8: attempt a table write while the result is held
      ld_en = 1'b1; ld_dim = 1'b0; ld_idx = '0; ld_bound = '0; ld_map = '0; ld_last = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; ld_last = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 held valid", 32'(res_valid), 1);
      check("R7 held map", 32'(res_map), 32'(hm));
      check("R7 held idx", 32'(res_idx), 32'(hi));
      check("R7 held hit", 32'(res_hit), 32'(hh));
      check("R6 ready low while held", 32'(q_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset ready", 32'(q_ready), 1);
    check("R7 reset valid", 32'(res_valid), 0);
    // R2: empty tables give no match
    query(8'd5, 8'd5, "R2 empty tables", 1'b0);

    // R1 R9: worked six-rule example
    load(0, 0, 8'd0,  6'b110111, 1'b0, 1'b1);
    load(0, 1, 8'd10, 6'b010011, 1'b0, 1'b1);
    load(0, 2, 8'd20, 6'b001001, 1'b1, 1'b1);
    load(1, 0, 8'd0,  6'b101100, 1'b0, 1'b1);
    load(1, 1, 8'd10, 6'b011000, 1'b0, 1'b1);
    load(1, 2, 8'd20, 6'b000111, 1'b1, 1'b1);
    query(8'd12, 8'd25, "R9 example", 1'b0);
    check("R9 example rule", 32'(res_idx), 4);
    query(8'd5, 8'd5, "R4 top rule", 1'b0);
    query(8'd10, 8'd20, "R2 on boundary", 1'b0);
    query(8'd12, 8'd5, "R5 empty intersection", 1'b0);
    query(8'd25, 8'd15, "R3 intersection", 1'b1);
    // R8: the write during the stall must not have zeroed entry 0
    query(8'd3, 8'd3, "R8 table unchanged", 1'b0);
    check("R8 entry kept", 32'(res_map), 32'(6'b100100));

    // R2: key below the first boundary
    load(0, 0, 8'd4, 6'b111111, 1'b0, 1'b1);
    query(8'd1, 8'd1, "R2 below first", 1'b0);
    // R10: shrink table 0 to two entries
    load(0, 1, 8'd10, 6'b000110, 1'b1, 1'b1);
    query(8'd200, 8'd2, "R10 shrunk table", 1'b0);
    check("R10 stale entry unused", 32'(res_map), 32'(6'b000100));

    // random tables
    void'($urandom(32'd7321));
    for (int set = 0; set < 4; set++) begin
      for (int d = 0; d < FIELDS; d++) begin
        int c = 1 + int'($urandom % ENT);
        int b = int'($urandom % 8);
        for (int i = 0; i < c; i++) begin
          load(d, i, 8'(b), N'($urandom), i == c - 1, 1'b1);
          b += 1 + int'($urandom % 18);
        end
      end
      for (int q = 0; q < 30; q++)
        query(8'($urandom), 8'($urandom), "R3 R4 random", q == 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule